// File: doc/BRIEF.md
# Circulating Multi-Tier Scan Chain Link Checker

The block tests the vertical links of a three-tier die stack by threading one serial scan chain through cells placed on every tier. Each cell is a multiplexer followed by a flip-flop. The chain starts on the top tier and descends tier by tier to the bottom. It then climbs back to the top. Every tier change along this route is one inter-tier link, modelled as an inline signal with a stuck-at-0 and a stuck-at-1 override for the testbench.

A test pattern, normally the alternating stream 1010..., is shifted in serially at the top tier while the mode input is low. When the mode input is raised, the chain closes into a ring and the pattern circulates indefinitely. A fault-free shadow ring is loaded with the same serial bits and rotates in lockstep with the chain. The destination cell, the last cell of the upward leg, is compared against the shadow on every circulation cycle. Mismatches are counted in a saturating error counter. After a programmed number of compares, the pass flag shows whether the counter is still zero.

The control sequence has three states. LOAD clears the counter and lets the chain shift. CIRC compares and counts. DONE holds the result. The transitions are:
- LOAD→CIRC, taken when mode is high.
- CIRC→DONE, taken on the last programmed compare.
- CIRC→LOAD and DONE→LOAD, taken when mode is low.
- Otherwise the state holds.

Top module: `tsv_loop_scan`

## Requirements
- R1: After reset, err_o is 0, pass_o is 0, cap_o is 0 and the control state is LOAD.
- R2: While mode_i is 0 (load), cell 0 takes sin_i on each clock and every other cell takes its predecessor. The captured output cap_o shows the bit driven N=12 clocks earlier if no fault is active.
- R3: While mode_i is 1 (circulate), cell 0 takes the value of the last cell, so a fault-free cap_o repeats with period 12.
- R4: Cells are visited in this tier order: top, top, middle, middle, bottom ×4, middle, middle, top, top. There are four links: link 0 sits between cells 1 and 2, link 1 between cells 3 and 4, link 2 between cells 7 and 8, and link 3 between cells 9 and 10.
- R5: stk0_i[j] forces a 0 into the cell after link j, and stk1_i[j] forces a 1. If both are set, the 0 wins. The faults act in both modes.
- R6: On each clock in state CIRC with mode_i high, err_o increments when cap_o differs from the fault-free shadow bit.
- R7: err_o saturates at 255 and never wraps.
- R8: CIRC performs max(1, cycles_i) compares and then enters DONE. In DONE, pass_o is 1 exactly when err_o is 0.
- R9: Lowering mode_i returns the block to LOAD. On the following clock, err_o and pass_o are cleared.
- R10: A fault that is active only during loading corrupts the stored pattern, and this is reported as errors during circulation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | 0 = load, 1 = circulate and check |
| sin_i | input | 1 | Serial pattern input at the top tier |
| cycles_i | input | 16 | Number of circulation compares |
| stk0_i | input | 4 | Per-link stuck-at-0 hooks |
| stk1_i | input | 4 | Per-link stuck-at-1 hooks |
| cap_o | output | 1 | Captured bit at the destination cell |
| err_o | output | 8 | Saturating mismatch count |
| pass_o | output | 1 | Test passed |

## Verification
The final compare of a run and the CIRC→DONE transition happen on the same clock edge. A mismatch on that last compare must still reach err_o and must clear pass_o. The randomized runs use short, random cycles_i values with links stuck only during circulation, which often puts a wrong bit at the destination exactly on that edge. The bench's cycle model decides the expected count and flag. A second collision, a saturated counter meeting further mismatches, is provoked by a long run with a stuck link and judged against the 255 ceiling.

// File: rtl/tsv_loop_pkg.sv
package tsv_loop_pkg;

    typedef enum logic [1:0] {
        ST_LOAD = 2'd0,
        ST_CIRC = 2'd1,
        ST_DONE = 2'd2
    } run_state_e;

    // tier index of chain position: down leg from top, then up leg from bottom
    function automatic int tier_at(input int pos, input int tiers, input int half);
        if (pos < tiers * half)
            return tiers - 1 - pos / half;
        else
            return (pos - tiers * half) / half;
    endfunction

    // index of the link between pos and pos+1, or -1 when both cells share a tier
    function automatic int link_at(input int pos, input int tiers, input int half);
        int idx;
        idx = 0;
        for (int p = 0; p < 2 * tiers * half - 1; p++) begin
            if (tier_at(p, tiers, half) != tier_at(p + 1, tiers, half)) begin
                if (p == pos) return idx;
                idx++;
            end
        end
        return -1;
    endfunction

endpackage

// File: rtl/tsv_cell_chain.sv
module tsv_cell_chain
    import tsv_loop_pkg::*;
#(
    parameter int TIERS = 3,
    parameter int HALF  = 2,
    parameter int N     = 12,
    parameter int LINKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             circ_i,
    input  logic             sin_i,
    input  logic [LINKS-1:0] stk0_i,
    input  logic [LINKS-1:0] stk1_i,
    output logic             tail_o
);

    logic [N-1:0] q;
    logic [N-1:0] d_in;

    generate
        for (genvar i = 0; i < N; i++) begin : g_cell
            if (i == 0) begin : g_head
                assign d_in[0] = circ_i ? q[N-1] : sin_i;
            end else begin : g_body
                localparam int LK = link_at(i - 1, TIERS, HALF);
                if (LK >= 0) begin : g_link
                    assign d_in[i] = stk0_i[LK] ? 1'b0 :
                                     stk1_i[LK] ? 1'b1 : q[i-1];
                end else begin : g_wire
                    assign d_in[i] = q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d_in;
    end

    assign tail_o = q[N-1];

endmodule

// File: rtl/tsv_ref_ring.sv
module tsv_ref_ring #(
    parameter int N = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic circ_i,
    input  logic sin_i,
    output logic tail_o
);

    logic [N-1:0] r;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= '0;
        else        r <= {r[N-2:0], circ_i ? r[N-1] : sin_i};
    end

    assign tail_o = r[N-1];

endmodule

// File: rtl/tsv_run_ctrl.sv
module tsv_run_ctrl
    import tsv_loop_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_i,
    input  logic [CNT_W-1:0] cycles_i,
    input  logic             tail_dut_i,
    input  logic             tail_ref_i,
    output logic [ERR_W-1:0] err_o,
    output logic             pass_o
);

    localparam logic [ERR_W-1:0] ERR_MAX = '1;

    run_state_e       st, st_nx;
    logic [CNT_W:0]   cnt;
    logic [ERR_W-1:0] err;
    logic             last_cmp;

    assign last_cmp = (cnt + 1'b1) >= {1'b0, cycles_i};

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_LOAD: if (mode_i)        st_nx = ST_CIRC;
            ST_CIRC: if (!mode_i)       st_nx = ST_LOAD;
                     else if (last_cmp) st_nx = ST_DONE;
            ST_DONE: if (!mode_i)       st_nx = ST_LOAD;
            default:                    st_nx = ST_LOAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_LOAD;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            err <= '0;
        end else if (st == ST_LOAD) begin
            cnt <= '0;
            err <= '0;
        end else if (st == ST_CIRC && mode_i) begin
            cnt <= cnt + 1'b1;
            if ((tail_dut_i != tail_ref_i) && (err != ERR_MAX))
                err <= err + 1'b1;
        end
    end

    always_comb begin
        err_o  = err;
        pass_o = (st == ST_DONE) && (err == '0);
    end

endmodule

// File: rtl/tsv_loop_scan.sv
module tsv_loop_scan #(
    parameter int TIERS          = 3,
    parameter int CELLS_PER_TIER = 4,
    parameter int CNT_W          = 16,
    parameter int ERR_W          = 8,
    localparam int LINKS         = 2 * (TIERS - 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_i,
    input  logic             sin_i,
    input  logic [CNT_W-1:0] cycles_i,
    input  logic [LINKS-1:0] stk0_i,
    input  logic [LINKS-1:0] stk1_i,
    output logic             cap_o,
    output logic [ERR_W-1:0] err_o,
    output logic             pass_o
);

    localparam int HALF = CELLS_PER_TIER / 2;
    localparam int N    = TIERS * CELLS_PER_TIER;

    logic tail_ref;

    tsv_cell_chain #(.TIERS(TIERS), .HALF(HALF), .N(N), .LINKS(LINKS)) u_chain (
        .clk    (clk),
        .rst_n  (rst_n),
        .circ_i (mode_i),
        .sin_i  (sin_i),
        .stk0_i (stk0_i),
        .stk1_i (stk1_i),
        .tail_o (cap_o)
    );

    tsv_ref_ring #(.N(N)) u_ref (
        .clk    (clk),
        .rst_n  (rst_n),
        .circ_i (mode_i),
        .sin_i  (sin_i),
        .tail_o (tail_ref)
    );

    tsv_run_ctrl #(.CNT_W(CNT_W), .ERR_W(ERR_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_i),
        .cycles_i   (cycles_i),
        .tail_dut_i (cap_o),
        .tail_ref_i (tail_ref),
        .err_o      (err_o),
        .pass_o     (pass_o)
    );

endmodule

// File: rtl/tsv_loop_scan_chk.sv
module tsv_loop_scan_chk #(
    parameter int ERR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_i,
    input logic [ERR_W-1:0] err_o,
    input logic             pass_o
);

    localparam logic [ERR_W-1:0] ERR_MAX = '1;

    // R6: the count never drops while circulation stays selected
    a_r6_err_monotone: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && $past(mode_i)) |-> (err_o >= $past(err_o)));

    // R7: a saturated count stays saturated while the run continues
    a_r7_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o == ERR_MAX && mode_i && $past(mode_i)) |=> (err_o == ERR_MAX));

    // R8: pass only with a zero count
    a_r8_pass_zero: assert property (@(posedge clk) disable iff (!rst_n)
        pass_o |-> (err_o == '0));

    // R8: pass only after a cycle in circulate mode
    a_r8_pass_mode: assert property (@(posedge clk) disable iff (!rst_n)
        pass_o |-> $past(mode_i));

    // R9: sustained load mode keeps the result cleared
    a_r9_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && !$past(mode_i) && !$past(mode_i, 2)) |-> (err_o == '0 && !pass_o));

endmodule

bind tsv_loop_scan tsv_loop_scan_chk #(.ERR_W(ERR_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (mode_i),
    .err_o  (err_o),
    .pass_o (pass_o)
);

// File: tb/sim_tsv_loop_scan.sv
module sim_tsv_loop_scan;

    localparam int N = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode = 1'b0;
    logic        sin = 1'b0;
    logic [15:0] cycles = 16'd0;
    logic [3:0]  stk0 = 4'd0;
    logic [3:0]  stk1 = 4'd0;
    logic        cap;
    logic [7:0]  err;
    logic        pass;

    int n_chk = 0;
    int n_fail = 0;

    // bench model of the requirements
    logic [N-1:0] mc = '0;
    logic [N-1:0] mr = '0;
    int           ms = 0;   // 0 LOAD, 1 CIRC, 2 DONE
    int           mcnt = 0;
    int           merr = 0;

    always #2 clk = ~clk;

    tsv_loop_scan u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .sin_i(sin), .cycles_i(cycles),
        .stk0_i(stk0), .stk1_i(stk1), .cap_o(cap), .err_o(err), .pass_o(pass)
    );

    // R4: link index behind cell pos
    function automatic int link_of(input int pos);
        case (pos)
            1: return 0;
            3: return 1;
            7: return 2;
            9: return 3;
            default: return -1;
        endcase
    endfunction

    task automatic chk(input int act, input int exp, input string tag);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input logic md, input logic sd, input logic [3:0] f0,
                        input logic [3:0] f1, input string tag);
        logic [N-1:0] nc;
        logic [N-1:0] nr;
        int lk;
        int lim;
        @(negedge clk);
        mode = md; sin = sd; stk0 = f0; stk1 = f1;
        for (int i = 0; i < N; i++) begin
            if (i == 0) begin
                nc[0] = md ? mc[N-1] : sd;
                nr[0] = md ? mr[N-1] : sd;
            end else begin
                nc[i] = mc[i-1];
                nr[i] = mr[i-1];
                lk = link_of(i - 1);
                if (lk >= 0) begin
                    if (f0[lk])      nc[i] = 1'b0;
                    else if (f1[lk]) nc[i] = 1'b1;
                end
            end
        end
        lim = (cycles == 16'd0) ? 1 : int'(cycles);
        if (ms == 0) begin
            merr = 0; mcnt = 0;
            ms = md ? 1 : 0;
        end else if (ms == 1) begin
            if (md) begin
                if (mc[N-1] != mr[N-1] && merr < 255) merr++;
                mcnt++;
                if (mcnt >= lim) ms = 2;
            end else ms = 0;
        end else begin
            if (!md) ms = 0;
        end
        mc = nc; mr = nr;
        @(posedge clk); #1;
        chk(int'(cap), int'(mc[N-1]), {tag, " cap"});
        chk(int'(err), merr, {tag, " err"});
        chk(int'(pass), (ms == 2 && merr == 0) ? 1 : 0, {tag, " pass"});
    endtask

    // load N bits (alternating when alt, else random), circulate, then return to load
    task automatic run(input bit alt, input int ncyc, input logic [3:0] l0, input logic [3:0] l1,
                       input logic [3:0] c0, input logic [3:0] c1, input string tag);
        cycles = 16'(ncyc);
        for (int i = 0; i < N; i++)
            step(1'b0, alt ? logic'(i % 2 == 0) : logic'($urandom % 2), l0, l1, {tag, " load"});
        for (int i = 0; i < ncyc + 2; i++)
            step(1'b1, 1'b0, c0, c1, {tag, " circ"});
    endtask

    initial begin
        #150000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        #9 rst_n = 1'b1;
        @(negedge clk);
        chk(int'(err), 0, "R1 reset err");
        chk(int'(pass), 0, "R1 reset pass");
        chk(int'(cap), 0, "R1 reset cap");

        // R2 R3 R8: fault-free alternating pattern passes
        run(1'b1, 40, 4'd0, 4'd0, 4'd0, 4'd0, "R2 R3 R8 clean");
        chk(int'(pass), 1, "R8 clean pass");
        // R9: back to load clears
        step(1'b0, 1'b0, 4'd0, 4'd0, "R9 exit");
        step(1'b0, 1'b0, 4'd0, 4'd0, "R9 exit");
        chk(int'(pass), 0, "R9 cleared pass");

        // R4 R5: each link stuck in both modes, each polarity
        for (int j = 0; j < 4; j++) begin
            run(1'b1, 30, 4'(1 << j), 4'd0, 4'(1 << j), 4'd0, "R4 R5 stuck0");
            chk(int'(err != 0), 1, "R5 stuck0 detected");
            step(1'b0, 1'b0, 4'd0, 4'd0, "R9 exit");
            run(1'b1, 30, 4'd0, 4'(1 << j), 4'd0, 4'(1 << j), "R4 R5 stuck1");
            chk(int'(pass), 0, "R5 stuck1 fails");
            step(1'b0, 1'b0, 4'd0, 4'd0, "R9 exit");
        end
        // R5: both hooks set, 0 wins
        run(1'b1, 24, 4'b1000, 4'b1000, 4'b1000, 4'b1000, "R5 both");
        step(1'b0, 1'b0, 4'd0, 4'd0, "R9 exit");

        // R10: fault only during load
        run(1'b1, 24, 4'b0010, 4'd0, 4'd0, 4'd0, "R10 load fault");
        chk(int'(err != 0), 1, "R10 detected");
        step(1'b0, 1'b0, 4'd0, 4'd0, "R9 exit");

        // R8: zero programmed cycles means one compare
        run(1'b1, 0, 4'd0, 4'd0, 4'd0, 4'd0, "R8 zero len");
        chk(int'(pass), 1, "R8 zero len pass");
        step(1'b0, 1'b0, 4'd0, 4'd0, "R9 exit");

        // R7: saturation on a long faulty run
        run(1'b1, 800, 4'b0001, 4'd0, 4'b0001, 4'd0, "R7 sat");
        chk(int'(err), 255, "R7 saturated");
        step(1'b0, 1'b0, 4'd0, 4'd0, "R9 exit");
        step(1'b0, 1'b0, 4'd0, 4'd0, "R9 exit");
        chk(int'(err), 0, "R9 cleared err");

        // R6: random patterns, faults during circulation only, short runs
        for (int k = 0; k < 30; k++) begin
            run(1'b0, 1 + int'($urandom % 40), 4'd0, 4'd0,
                4'($urandom % 16) & 4'($urandom % 16), 4'($urandom % 16) & 4'($urandom % 16),
                "R6 random");
            step(1'b0, 1'b0, 4'd0, 4'd0, "R9 exit");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule